// File: doc/BRIEF.md
# Instruction TLB lookup

This block turns instruction-fetch virtual addresses into physical addresses through a set-associative translation table. Every way keeps, for each set, two 32-bit words. The match word holds a virtual tag, a valid bit and an age field. The translate word holds a physical frame, a cache-inhibit bit and separate execute enables for supervisor and user mode. Software loads both words through an address-decoded register port. The same port decoding is used to read the words back, so the age field can be inspected.

The fetch port accepts one request per cycle and returns a registered result on the next cycle. The result carries the physical address, the cache-inhibit flag, a hit or miss indication and a page-fault flag with the faulting address. A hit refreshes the age field of the entry that hit. A miss advances a wrapping miss counter.

A separate combinational probe port runs the same tag match and permission check. It returns the physical address, or zero on a miss or a denied access. It changes no stored state and drives no fetch output.

Top module: `itlb_xlate`

## Requirements
- R1: After synchronous reset, `f_valid`, `f_hit`, `f_miss`, `f_fault`, `f_ci`, `f_paddr`, `f_fault_addr` and `miss_count` are zero. Every stored word reads back as zero, so no entry is valid.
- R2: With the default 8 KiB page (13 offset bits) and 16 sets, the set index is address bits [16:13]. The tag is address bits [31:17], compared against match-word bits [31:17]. A way hits only when its tags are equal and match-word bit 0 (valid) is 1. Otherwise the lookup misses.
- R3: When several ways of the selected set hit, the translation comes from the highest-numbered hitting way.
- R4: On a hit, the physical address is translate-word bits [31:13] followed by virtual address bits [12:0]. `f_ci` reports translate-word bit 1.
- R5: On a hit, execution is allowed when `f_super`=1 and translate-word bit 6 is set, or when `f_super`=0 and translate-word bit 7 is set. Otherwise `f_fault`=1 with `f_fault_addr` equal to the virtual address, `f_hit` stays 1 and `f_paddr` still carries the translation. Without a fault, `f_fault_addr` is zero.
- R6: On a fetch hit, match-word bits [9:6] of the hitting entry become NUM_SETS-1 (15). All other bits of that word keep their values.
- R7: On a fetch miss, `f_miss`=1, `f_hit`=0, `f_fault`=0, `f_ci`=0 and `f_paddr`=0, and `miss_count` increases by one.
- R8: Every fetch result appears with `f_valid`=1 exactly one cycle after the request cycle, and `f_valid` is 0 otherwise. In a valid result, `f_miss` is the inverse of `f_hit` and never coincides with `f_fault`.
- R9: `p_paddr` equals the R4 translation in the same cycle when the probe hits and R5 allows execution. It is zero on a miss or a denial. A probe changes no age field, no `miss_count` and no fetch output.
- R10: Register address layout: bits [3:0] select the set, bits [5:4] the way, and bit 6 selects the translate word (1) or the match word (0). A write takes effect at the next clock edge. A fetch in the same cycle still sees the old contents. A match-word write to the entry that a same-cycle fetch hits overrides that fetch's age refresh.
- R11: `rd_data` returns, in the same cycle, the word that `rd_addr` selects using the R10 layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 7 | Write address: set, way, word select |
| wr_data | input | 32 | Write data |
| rd_addr | input | 7 | Readback address, same layout |
| rd_data | output | 32 | Readback word |
| f_req | input | 1 | Fetch lookup request |
| f_vaddr | input | 32 | Fetch virtual address |
| f_super | input | 1 | Fetch privilege: 1 supervisor, 0 user |
| f_valid | output | 1 | Fetch result strobe |
| f_hit | output | 1 | Fetch hit |
| f_miss | output | 1 | Fetch miss |
| f_fault | output | 1 | Instruction page fault |
| f_ci | output | 1 | Cache-inhibit of hit entry |
| f_paddr | output | 32 | Translated physical address |
| f_fault_addr | output | 32 | Faulting virtual address |
| miss_count | output | 16 | Wrapping fetch miss count |
| p_vaddr | input | 32 | Probe virtual address |
| p_super | input | 1 | Probe privilege |
| p_paddr | output | 32 | Probe result, zero on miss or denial |

## Verification
All fetch outputs and `miss_count` are due at the first clock edge after the request cycle. The bench drives each request on a falling edge, lowers it on the next falling edge and reads the result there, half a cycle after it was registered. Probe results and readback words are combinational, so they are sampled 1 ns after their inputs change. Age refreshes and writes land at the same edge as the fetch result, so readback checks of stored words follow the result sample. The same-cycle test applies a write and a fetch on one falling edge, then checks both the fetch result (old contents) and the stored word (new contents) at the next one.

// File: rtl/itlb_pkg.sv
package itlb_pkg;
    localparam int ADDR_W       = 32;
    localparam int MW_VALID_BIT = 0;
    localparam int MW_AGE_LSB   = 6;
    localparam int TW_CI_BIT    = 1;
    localparam int TW_SXE_BIT   = 6;
    localparam int TW_UXE_BIT   = 7;

    typedef struct packed {
        logic              valid;
        logic              hit;
        logic              miss;
        logic              fault;
        logic              ci;
        logic [ADDR_W-1:0] paddr;
        logic [ADDR_W-1:0] fault_addr;
    } fetch_rsp_t;

    function automatic logic exec_allowed(input logic [ADDR_W-1:0] tw, input logic sup);
        return sup ? tw[TW_SXE_BIT] : tw[TW_UXE_BIT];
    endfunction
endpackage

// File: rtl/itlb_store.sv
module itlb_store
    import itlb_pkg::*;
#(
    parameter int NUM_WAYS = 4,
    parameter int NUM_SETS = 16,
    parameter int SET_W    = 4,
    parameter int WAY_W    = 2
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             wr_en,
    input  logic                             wr_xlat,
    input  logic [WAY_W-1:0]                 wr_way,
    input  logic [SET_W-1:0]                 wr_set,
    input  logic [ADDR_W-1:0]                wr_data,
    input  logic                             age_en,
    input  logic [WAY_W-1:0]                 age_way,
    input  logic [SET_W-1:0]                 age_set,
    input  logic [SET_W-1:0]                 f_set,
    input  logic [SET_W-1:0]                 p_set,
    input  logic                             rd_xlat,
    input  logic [WAY_W-1:0]                 rd_way,
    input  logic [SET_W-1:0]                 rd_set,
    output logic [NUM_WAYS-1:0][ADDR_W-1:0]  f_mw,
    output logic [NUM_WAYS-1:0][ADDR_W-1:0]  f_tw,
    output logic [NUM_WAYS-1:0][ADDR_W-1:0]  p_mw,
    output logic [NUM_WAYS-1:0][ADDR_W-1:0]  p_tw,
    output logic [ADDR_W-1:0]                rd_data
);
    localparam logic [SET_W-1:0] AGE_FULL = SET_W'(NUM_SETS - 1);

    logic [ADDR_W-1:0] mw_q [NUM_WAYS][NUM_SETS];
    logic [ADDR_W-1:0] tw_q [NUM_WAYS][NUM_SETS];

    logic wr_way_ok, age_way_ok, rd_way_ok;
    assign wr_way_ok  = (32'(wr_way)  < NUM_WAYS);
    assign age_way_ok = (32'(age_way) < NUM_WAYS);
    assign rd_way_ok  = (32'(rd_way)  < NUM_WAYS);

    // Age refresh first, register write last: a write to the same word wins.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < NUM_WAYS; w++) begin
                for (int s = 0; s < NUM_SETS; s++) begin
                    mw_q[w][s] <= '0;
                    tw_q[w][s] <= '0;
                end
            end
        end else begin
            if (age_en && age_way_ok)
                mw_q[age_way][age_set][MW_AGE_LSB +: SET_W] <= AGE_FULL;
            if (wr_en && wr_way_ok) begin
                if (wr_xlat) tw_q[wr_way][wr_set] <= wr_data;
                else         mw_q[wr_way][wr_set] <= wr_data;
            end
        end
    end

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_rd
        assign f_mw[w] = mw_q[w][f_set];
        assign f_tw[w] = tw_q[w][f_set];
        assign p_mw[w] = mw_q[w][p_set];
        assign p_tw[w] = tw_q[w][p_set];
    end

    always_comb begin
        rd_data = '0;
        if (rd_way_ok)
            rd_data = rd_xlat ? tw_q[rd_way][rd_set] : mw_q[rd_way][rd_set];
    end

    // R6: age field of the hit entry reads full after the edge, unless overwritten
    p_age_refresh_r6: assert property (@(posedge clk) disable iff (rst)
        (age_en && age_way_ok && !(wr_en && !wr_xlat && wr_way == age_way && wr_set == age_set))
        |=> (mw_q[$past(age_way)][$past(age_set)][MW_AGE_LSB +: SET_W] == AGE_FULL));

    // R10: a match-word write lands whole at the next edge
    p_write_lands_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_xlat && wr_way_ok)
        |=> (mw_q[$past(wr_way)][$past(wr_set)] == $past(wr_data)));
endmodule

// File: rtl/itlb_match.sv
module itlb_match
    import itlb_pkg::*;
#(
    parameter int NUM_WAYS  = 4,
    parameter int SET_W     = 4,
    parameter int PAGE_BITS = 13,
    parameter int WAY_W     = 2
) (
    input  logic [ADDR_W-1:0]               vaddr,
    input  logic                            sup,
    input  logic [NUM_WAYS-1:0][ADDR_W-1:0] mw,
    input  logic [NUM_WAYS-1:0][ADDR_W-1:0] tw,
    output logic                            hit,
    output logic [WAY_W-1:0]                way,
    output logic [ADDR_W-1:0]               paddr,
    output logic                            ci,
    output logic                            allow
);
    localparam int TAG_LSB = PAGE_BITS + SET_W;

    logic [NUM_WAYS-1:0] way_hit;
    logic [ADDR_W-1:0]   sel_tw;

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
        assign way_hit[w] = mw[w][MW_VALID_BIT] &&
                            (mw[w][ADDR_W-1:TAG_LSB] == vaddr[ADDR_W-1:TAG_LSB]);
    end

    // Ascending scan: the last (highest) hitting way is kept.
    always_comb begin
        way = '0;
        for (int w = 0; w < NUM_WAYS; w++)
            if (way_hit[w]) way = WAY_W'(w);
    end

    assign hit    = |way_hit;
    assign sel_tw = tw[way];
    assign paddr  = {sel_tw[ADDR_W-1:PAGE_BITS], vaddr[PAGE_BITS-1:0]};
    assign ci     = sel_tw[TW_CI_BIT];
    assign allow  = exec_allowed(sel_tw, sup);

    // R3: the chosen way hits and no higher way does
    always_comb begin
        if (!$isunknown(way_hit) && hit)
            p_top_way_r3: assert (way_hit[way] && ((way_hit >> way) >> 1) == '0);
    end
endmodule

// File: rtl/itlb_xlate.sv
module itlb_xlate
    import itlb_pkg::*;
#(
    parameter int NUM_WAYS  = 4,
    parameter int NUM_SETS  = 16,
    parameter int PAGE_BITS = 13,
    parameter int CNT_W     = 16,
    localparam int SET_W    = (NUM_SETS > 2) ? $clog2(NUM_SETS) : 1,
    localparam int WAY_W    = (NUM_WAYS > 2) ? $clog2(NUM_WAYS) : 1,
    localparam int REG_AW   = SET_W + WAY_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic [REG_AW-1:0] rd_addr,
    output logic [ADDR_W-1:0] rd_data,
    input  logic              f_req,
    input  logic [ADDR_W-1:0] f_vaddr,
    input  logic              f_super,
    output logic              f_valid,
    output logic              f_hit,
    output logic              f_miss,
    output logic              f_fault,
    output logic              f_ci,
    output logic [ADDR_W-1:0] f_paddr,
    output logic [ADDR_W-1:0] f_fault_addr,
    output logic [CNT_W-1:0]  miss_count,
    input  logic [ADDR_W-1:0] p_vaddr,
    input  logic              p_super,
    output logic [ADDR_W-1:0] p_paddr
);
    logic [SET_W-1:0] f_set, p_set;
    assign f_set = f_vaddr[PAGE_BITS +: SET_W];
    assign p_set = p_vaddr[PAGE_BITS +: SET_W];

    logic [NUM_WAYS-1:0][ADDR_W-1:0] f_mw, f_tw, p_mw, p_tw;
    logic              fm_hit, fm_ci, fm_allow;
    logic [WAY_W-1:0]  fm_way;
    logic [ADDR_W-1:0] fm_paddr;
    logic              pm_hit, pm_ci, pm_allow;
    logic [WAY_W-1:0]  pm_way;
    logic [ADDR_W-1:0] pm_paddr;

    itlb_store #(.NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS), .SET_W(SET_W), .WAY_W(WAY_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_xlat (wr_addr[REG_AW-1]),
        .wr_way  (wr_addr[SET_W +: WAY_W]),
        .wr_set  (wr_addr[SET_W-1:0]),
        .wr_data (wr_data),
        .age_en  (f_req && fm_hit),
        .age_way (fm_way),
        .age_set (f_set),
        .f_set   (f_set),
        .p_set   (p_set),
        .rd_xlat (rd_addr[REG_AW-1]),
        .rd_way  (rd_addr[SET_W +: WAY_W]),
        .rd_set  (rd_addr[SET_W-1:0]),
        .f_mw    (f_mw),
        .f_tw    (f_tw),
        .p_mw    (p_mw),
        .p_tw    (p_tw),
        .rd_data (rd_data)
    );

    itlb_match #(.NUM_WAYS(NUM_WAYS), .SET_W(SET_W), .PAGE_BITS(PAGE_BITS), .WAY_W(WAY_W)) u_fetch_match (
        .vaddr (f_vaddr), .sup (f_super), .mw (f_mw), .tw (f_tw),
        .hit (fm_hit), .way (fm_way), .paddr (fm_paddr), .ci (fm_ci), .allow (fm_allow)
    );

    itlb_match #(.NUM_WAYS(NUM_WAYS), .SET_W(SET_W), .PAGE_BITS(PAGE_BITS), .WAY_W(WAY_W)) u_probe_match (
        .vaddr (p_vaddr), .sup (p_super), .mw (p_mw), .tw (p_tw),
        .hit (pm_hit), .way (pm_way), .paddr (pm_paddr), .ci (pm_ci), .allow (pm_allow)
    );

    assign p_paddr = (pm_hit && pm_allow) ? pm_paddr : '0;

    fetch_rsp_t       rsp_d, rsp_q;
    logic [CNT_W-1:0] miss_q;

    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = f_req;
        if (f_req) begin
            rsp_d.hit        = fm_hit;
            rsp_d.miss       = !fm_hit;
            rsp_d.fault      = fm_hit && !fm_allow;
            rsp_d.ci         = fm_hit && fm_ci;
            rsp_d.paddr      = fm_hit ? fm_paddr : '0;
            rsp_d.fault_addr = (fm_hit && !fm_allow) ? f_vaddr : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q  <= '0;
            miss_q <= '0;
        end else begin
            rsp_q <= rsp_d;
            if (f_req && !fm_hit) miss_q <= miss_q + 1'b1;
        end
    end

    assign f_valid      = rsp_q.valid;
    assign f_hit        = rsp_q.hit;
    assign f_miss       = rsp_q.miss;
    assign f_fault      = rsp_q.fault;
    assign f_ci         = rsp_q.ci;
    assign f_paddr      = rsp_q.paddr;
    assign f_fault_addr = rsp_q.fault_addr;
    assign miss_count   = miss_q;

    p_valid_next_r8: assert property (@(posedge clk) disable iff (rst)
        f_req |=> f_valid);

    p_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !f_req |=> !f_valid && !f_hit && !f_miss && !f_fault);

    p_flags_excl_r8: assert property (@(posedge clk) disable iff (rst)
        f_valid |-> (f_miss != f_hit) && !(f_miss && f_fault));

    p_fault_addr_r5: assert property (@(posedge clk) disable iff (rst)
        f_fault |-> f_hit && (f_fault_addr == $past(f_vaddr)));

    p_miss_step_r7: assert property (@(posedge clk) disable iff (rst)
        (f_valid && f_miss) |-> (miss_count == CNT_W'($past(miss_count) + 1'b1)));
endmodule

// File: tb/itlb_xlate_bench.sv
module itlb_xlate_bench;
    localparam int NW = 4;
    localparam int NS = 16;
    localparam int PG = 8192;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [6:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [6:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        f_req = 1'b0;
    logic [31:0] f_vaddr = '0;
    logic        f_super = 1'b0;
    logic        f_valid, f_hit, f_miss, f_fault, f_ci;
    logic [31:0] f_paddr, f_fault_addr;
    logic [15:0] miss_count;
    logic [31:0] p_vaddr = '0;
    logic        p_super = 1'b0;
    logic [31:0] p_paddr;

    itlb_xlate u_itlb_xlate (
        .clk (clk), .rst (rst), .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
        .rd_addr (rd_addr), .rd_data (rd_data), .f_req (f_req), .f_vaddr (f_vaddr),
        .f_super (f_super), .f_valid (f_valid), .f_hit (f_hit), .f_miss (f_miss),
        .f_fault (f_fault), .f_ci (f_ci), .f_paddr (f_paddr), .f_fault_addr (f_fault_addr),
        .miss_count (miss_count), .p_vaddr (p_vaddr), .p_super (p_super), .p_paddr (p_paddr)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    logic [31:0] mw_m [NW][NS];
    logic [31:0] tw_m [NW][NS];
    logic [15:0] miss_m = '0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] radr(input bit xl, input int way, input int set);
        return {xl, 2'(way), 4'(set)};
    endfunction

    task automatic reg_wr(input bit xl, input int way, input int set, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = radr(xl, way, set); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (xl) tw_m[way][set] = d; else mw_m[way][set] = d;
    endtask

    function automatic void model(input logic [31:0] va, input bit sup,
                                  output bit hit, output int way, output bit ok);
        int set;
        logic [31:0] tag;
        set = int'((va / PG) % NS);
        tag = va / (PG * NS);
        hit = 1'b0; way = 0;
        for (int w = 0; w < NW; w++)
            if (mw_m[w][set][0] && (mw_m[w][set] / (PG * NS)) == tag) begin
                hit = 1'b1; way = w;
            end
        ok = hit && (sup ? tw_m[way][set][6] : tw_m[way][set][7]);
    endfunction

    function automatic logic [31:0] xlate(input logic [31:0] tw, input logic [31:0] va);
        return (tw / PG) * PG + (va % PG);
    endfunction

    task automatic fetch(input logic [31:0] va, input bit sup, input string req);
        bit h, ok; int w, s;
        logic [31:0] exp_pa;
        model(va, sup, h, w, ok);
        s = int'((va / PG) % NS);
        exp_pa = h ? xlate(tw_m[w][s], va) : 32'd0;
        @(negedge clk);
        f_req = 1'b1; f_vaddr = va; f_super = sup;
        @(negedge clk);
        f_req = 1'b0;
        if (!h) miss_m++;
        chk({req, " R8 valid"}, 32'(f_valid), 32'd1);
        chk({req, " hit"},      32'(f_hit), 32'(h));
        chk({req, " R7 miss"},  32'(f_miss), 32'(!h));
        chk({req, " R5 fault"}, 32'(f_fault), 32'(h && !ok));
        chk({req, " R5 faddr"}, f_fault_addr, (h && !ok) ? va : 32'd0);
        chk({req, " R4 paddr"}, f_paddr, exp_pa);
        chk({req, " R4 ci"},    32'(f_ci), h ? 32'(tw_m[w][s][1]) : 32'd0);
        chk({req, " R7 count"}, 32'(miss_count), 32'(miss_m));
        if (h) begin
            mw_m[w][s] = (mw_m[w][s] & ~(32'hF << 6)) | (32'd15 << 6);
            rd_addr = radr(1'b0, w, s);
            #1 chk({req, " R6 age"}, rd_data, mw_m[w][s]);
        end
    endtask

    function automatic logic [31:0] tag_of(input int w, input int s);
        return 32'(w * 100 + s + 5);
    endfunction

    function automatic logic [31:0] va_of(input int w, input int s);
        return (tag_of(w, s) << 17) | (32'(s) << 13) | 32'((s * 523 + w * 97) % PG);
    endfunction

    initial begin
        #(200000 * 10);
        checks++; errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] va, old_pa, newd;
        bit h, ok; int w;
        for (int a = 0; a < NW; a++)
            for (int b = 0; b < NS; b++) begin mw_m[a][b] = '0; tw_m[a][b] = '0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 valid", 32'(f_valid), 0);
        chk("R1 flags", 32'({f_hit, f_miss, f_fault, f_ci}), 0);
        chk("R1 paddr", f_paddr, 0);
        chk("R1 count", 32'(miss_count), 0);
        rd_addr = radr(1'b0, 2, 7); #1 chk("R1 R11 mw readback", rd_data, 0);
        rd_addr = radr(1'b1, 3, 15); #1 chk("R1 R11 tw readback", rd_data, 0);
        p_vaddr = 32'h0; #1 chk("R1 R9 probe", p_paddr, 0);

        // R10 R11 fill every entry and read it back
        for (int s = 0; s < NS; s++)
            for (int ww = 0; ww < NW; ww++) begin
                reg_wr(1'b0, ww, s, (tag_of(ww, s) << 17) | 32'(!(ww == 2 && s == 9)));
                reg_wr(1'b1, ww, s, (32'(s * 7 + ww * 1000 + 3) << 13) | (32'(s % 2) << 1)
                       | (32'(ww != 2) << 6) | (32'(ww != 1 && !(ww == 3 && (s / 2) % 2 == 1)) << 7));
                rd_addr = radr(1'b0, ww, s); #1 chk("R10 R11 mw", rd_data, mw_m[ww][s]);
                rd_addr = radr(1'b1, ww, s); #1 chk("R10 R11 tw", rd_data, tw_m[ww][s]);
            end

        // R2 R4 R5 R6 sweep every entry in both privilege modes
        for (int s = 0; s < NS; s++)
            for (int ww = 0; ww < NW; ww++) begin
                fetch(va_of(ww, s), 1'b1, "R2 sweep sup");
                fetch(va_of(ww, s), 1'b0, "R2 sweep usr");
            end

        // R7 R2 misses: unknown tag, right tag in wrong set
        fetch(32'hFFFF_E123, 1'b1, "R7 unknown tag");
        fetch((tag_of(1, 5) << 17) | (32'd6 << 13), 1'b1, "R2 wrong set");

        // R3 duplicate tag: way1 and way3 of set 5
        reg_wr(1'b0, 1, 5, mw_m[3][5]);
        fetch(va_of(3, 5), 1'b1, "R3 dup hi way");
        chk("R3 chosen frame", f_paddr, xlate(tw_m[3][5], va_of(3, 5)));
        reg_wr(1'b0, 3, 5, 32'd0);
        fetch(va_of(3, 5), 1'b1, "R3 dup after clear");
        chk("R3 lower way frame", f_paddr, xlate(tw_m[1][5], va_of(3, 5)));

        // R9 probe: translation, denial, miss, no side effects
        rd_addr = radr(1'b0, 0, 4);
        p_vaddr = va_of(0, 4); p_super = 1'b1; #1
        chk("R9 probe hit", p_paddr, xlate(tw_m[0][4], va_of(0, 4)));
        p_vaddr = va_of(1, 4); p_super = 1'b0; #1
        chk("R9 probe denied", p_paddr, 0);
        p_vaddr = 32'hFFFF_E000; #1
        chk("R9 probe miss", p_paddr, 0);
        mw_m[0][4] = mw_m[0][4] & ~(32'hF << 6);
        reg_wr(1'b0, 0, 4, mw_m[0][4]);
        p_vaddr = va_of(0, 4); p_super = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9 probe age kept", rd_data, mw_m[0][4]);
        chk("R9 probe count kept", 32'(miss_count), 32'(miss_m));
        chk("R9 probe no fetch out", 32'({f_valid, f_hit, f_miss, f_fault}), 0);

        // R10 same-cycle match-word write and fetch hit on that entry
        va = va_of(0, 3);
        model(va, 1'b1, h, w, ok);
        old_pa = xlate(tw_m[w][3], va);
        newd = (32'h7ABC << 17) | 32'd1;
        @(negedge clk);
        f_req = 1'b1; f_vaddr = va; f_super = 1'b1;
        wr_en = 1'b1; wr_addr = radr(1'b0, 0, 3); wr_data = newd;
        @(negedge clk);
        f_req = 1'b0; wr_en = 1'b0;
        mw_m[0][3] = newd;
        chk("R10 old entry hit", 32'(f_hit), 1);
        chk("R10 old frame", f_paddr, old_pa);
        rd_addr = radr(1'b0, 0, 3); #1 chk("R10 write beats age", rd_data, newd);
        fetch(va, 1'b1, "R10 after retag");

        // R10 same-cycle translate-word write: fetch sees old frame, next sees new
        va = va_of(0, 6);
        old_pa = xlate(tw_m[0][6], va);
        newd = (32'h1234 << 13) | (32'd1 << 6) | (32'd1 << 7);
        @(negedge clk);
        f_req = 1'b1; f_vaddr = va; f_super = 1'b0;
        wr_en = 1'b1; wr_addr = radr(1'b1, 0, 6); wr_data = newd;
        @(negedge clk);
        f_req = 1'b0; wr_en = 1'b0;
        tw_m[0][6] = newd;
        mw_m[0][6] = (mw_m[0][6] & ~(32'hF << 6)) | (32'd15 << 6);
        chk("R10 old tw frame", f_paddr, old_pa);
        fetch(va, 1'b0, "R10 new tw");

        @(negedge clk);
        chk("R8 idle valid", 32'(f_valid), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule